// File: doc/BRIEF.md
# Ones-Complement Sample Widener

This block takes a stream of 12-bit one's complement samples, such as words read back from a tape recorder, and returns each one as a 32-bit two's complement integer. The samples span -2047 to +2047. The bits of the input word above the 12-bit sample may hold any value, and the block ignores them.

The conversion copies the sample's sign bit into every upper bit of the result. It then adds one when that sign bit is set. Positive samples have the same encoding in both number systems, so they pass through unchanged. The one's complement negative zero (all twelve bits set) becomes zero through the same add-one path, with no separate case for it. Both sides of the block use a valid/ready handshake. One register stage sits between them, and it holds its contents while the downstream side stalls.

Top module: `oc_widen`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid` at the next rising clock edge. While `out_valid` is low, `in_ready` is high.
- R2: A sample with bit 11 clear appears on `out_data` zero-extended, with the same numeric value.
- R3: A sample with bit 11 set appears on `out_data` as the negative two's complement integer -(~s[10:0]). For example, 12'h800 gives -2047 and 12'hFFE gives -1.
- R4: The negative-zero code 12'hFFF gives an `out_data` of exactly 0.
- R5: Bits 12 and above of `in_word` have no effect on `out_data`.
- R6: A transfer takes place when `in_valid` and `in_ready` are both high at a clock edge. The converted result and a high `out_valid` are present from that edge on, so the latency is one cycle.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` hold their values.
- R8: When `out_valid` is high, `out_ready` is high and no new transfer arrives, `out_valid` goes low at the edge.
- R9: Every valid result lies in the range -2047 to +2047.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input word is valid |
| in_ready | output | 1 | The block can accept a word |
| in_word | input | IN_W (32) | Sample in bits 11:0; the upper bits are ignored |
| out_valid | output | 1 | The result is valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | OUT_W (32) | Two's complement result |

## Verification
The checker runs on every cycle. It covers the reset state of `out_valid` and the holding of the result during a stall. It also checks that every accepted word produces a valid result one cycle later, that no result falls outside ±2047, and that a transfer with bit 11 set never yields a positive result. Exact numeric correctness can only be shown by the bench. It sweeps all 4096 sample codes, each with random garbage in the upper bits, and compares every result with an arithmetic model. The bench also covers stall and drain sequences and a reset that arrives while a result is pending.

// File: rtl/oc_widen.sv
module oc_widen #(
  parameter int IN_W     = 32,
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int EXT_W = OUT_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] sample;
  logic                neg;
  logic [OUT_W-1:0]    widened;
  logic [OUT_W-1:0]    result;
  logic                take;
  logic                unused_hi;

  assign sample    = in_word[SAMPLE_W-1:0];
  assign unused_hi = ^in_word[IN_W-1:SAMPLE_W];
  assign neg       = sample[SAMPLE_W-1];
  assign widened   = {{EXT_W{neg}}, sample};
  assign result    = widened + {{(OUT_W-1){1'b0}}, neg};

  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= result;
  end
endmodule

// File: rtl/oc_widen_chk.sv
module oc_widen_chk #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_word,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_neg_not_positive_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[11]) |=> (out_data[OUT_W-1] || out_data == '0));

  assert_accept_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($signed(out_data) >= -2047 && $signed(out_data) <= 2047));
endmodule

bind oc_widen oc_widen_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/oc_widen_tb.sv
`timescale 1ns/1ps
module oc_widen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  oc_widen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [31:0] model(input logic [11:0] s);
    int v;
    if (s[11]) v = -int'({21'd0, ~s[10:0]});
    else       v = int'({20'd0, s});
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] s, input logic [19:0] junk, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = {junk, s};
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, model(s));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    for (int c = 0; c < 4096; c++) begin
      logic [11:0] s;
      s = 12'(c);
      if (s == 12'hFFF)  send(s, 20'($urandom), "R4 negative zero");
      else if (s[11])    send(s, 20'($urandom), "R3 negative sample");
      else               send(s, 20'($urandom), "R2 positive sample");
    end

    send(12'h005, 20'hFFFFF, "R5 ones above sample");
    send(12'h005, 20'h00000, "R5 zeros above sample");
    send(12'h800, 20'hA5A5A, "R3 most negative");
    send(12'h7FF, 20'h5A5A5, "R2 most positive");

    @(negedge clk);
    check("R8 drained", {31'd0, out_valid}, 32'd0);

    out_ready = 1'b0;
    send(12'hF00, 20'h12345, "R6 load before stall");
    check("R7 in_ready low in stall", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_word = 32'h0000_0123;
    repeat (3) begin
      @(negedge clk);
      check("R7 held data", out_data, model(12'hF00));
      check("R7 held valid", {31'd0, out_valid}, 32'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 after stall release", out_data, model(12'h123));
    @(negedge clk);
    check("R8 drain after release", {31'd0, out_valid}, 32'd0);

    out_ready = 1'b0;
    send(12'h001, 20'h0, "R6 pending before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset while pending", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule